// File: doc/BRIEF.md
# Clocked programmable pulse delay line

This block retimes a single-bit signal by a whole number of clock cycles chosen by a 7-bit select word. The delay is a fixed base latency plus a fixed step for each count of the select word. The input runs through a chain of registers. A multiplexer picks one stage of the chain, using the select word directly with no capture register. The picked bit drives two outputs, one true and one complemented.

An active-low enable gates both outputs. While it is high, the true output is held low and the complemented output is held high. The chain keeps shifting underneath. A small state machine watches the input for high or low levels that are too short for the delay currently selected. When it sees one, it raises a flag that stays set until reset.

The pulse-width monitor has three states:
- `PW_SETTLE`: after reset, waiting for the first input change.
- `PW_TRACK`: measuring the length of each level.
- `PW_FAULT`: the sticky error state.

It has three transitions:
- The first change moves `PW_SETTLE` to `PW_TRACK`.
- A change that ends a level shorter than the minimum moves `PW_TRACK` to `PW_FAULT`.
- Only reset leaves `PW_FAULT`.

Top module: `pulse_delay_line`

## Requirements
- R1: While the enable is low, `dout` in any cycle equals `din` from BASE_CYC + STEP_CYC*`sel` cycles earlier (defaults 1 and 1).
- R2: All select values from 0 to 127 are usable. The shortest delay, 1 cycle, is at `sel`=0 and the longest, 128 cycles, is at `sel`=127.
- R3: The delay never shrinks as `sel` grows. `sel` is not registered, so a new value picks its stage in the same cycle it is applied.
- R4: While `en_n` is low, `dout_n` is always the inverse of `dout`.
- R5: While `en_n` is high, `dout` is 0 and `dout_n` is 1, whatever the delayed data is.
- R6: The chain keeps shifting while the outputs are disabled. After `en_n` returns low, the outputs show the correctly delayed data in that same cycle.
- R7: A synchronous active-high `rst` clears every stage of the chain. Until new data has travelled through, `dout` reads 0 and `dout_n` reads 1.
- R8: A level of `din` is measured from one input change to the next. If the level lasted fewer than ceil(8*D/100) cycles, where D is the delay selected when it ended, `pw_err` is set from the next cycle on. The level in progress when reset is released is not measured.
- R9: Once set, `pw_err` stays 1 until `rst` is applied.
- R10: Levels that are at least the minimum length leave `pw_err` at 0. The boundary cases are 11 cycles at `sel`=127 and 1 cycle at `sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to be delayed |
| sel | input | 7 | Delay select word, used unregistered |
| en_n | input | 1 | Output enable, active low |
| dout | output | 1 | Delayed signal, forced low while disabled |
| dout_n | output | 1 | Complement of `dout`, forced high while disabled |
| pw_err | output | 1 | Sticky flag for a too-short input level |

## Verification
On every cycle, the assertions check four things:
- the forced output levels while the block is disabled;
- the complementary relation between `dout` and `dout_n` while it is enabled;
- that the error flag stays set once raised;
- that the error flag only rises right after an input change, and that the outputs are clear straight after reset.

The exact delay for each select value can only be shown by the bench's scenarios. The same goes for a select change taking effect in the same cycle, data surviving a disabled stretch, and the 10-versus-11-cycle boundary of the width check. The bench compares these against a history of the input that it keeps for itself.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Pulse-width monitor states
    typedef enum logic [1:0] {
        PW_SETTLE = 2'd0,
        PW_TRACK  = 2'd1,
        PW_FAULT  = 2'd2
    } pw_state_t;

    // Smallest whole number of cycles not below pct percent of total
    function automatic int unsigned ceil_pct(input int unsigned total,
                                             input int unsigned pct);
        return (total * pct + 99) / 100;
    endfunction

endpackage

// File: rtl/pdl_tap_chain.sv
module pdl_tap_chain #(
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);

    // stages[i] holds din from i+1 cycles ago
    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            stages <= {stages[DEPTH-2:0], din};
        end
    end

endmodule

// File: rtl/pdl_tap_mux.sv
module pdl_tap_mux #(
    parameter int ADDR_W   = 7,
    parameter int BASE_CYC = 1,
    parameter int STEP_CYC = 1,
    parameter int DEPTH    = BASE_CYC + STEP_CYC * ((1 << ADDR_W) - 1)
) (
    input  logic [DEPTH-1:0]  stages,
    input  logic [ADDR_W-1:0] sel,
    output logic              tap
);

    localparam int N_TAPS = 1 << ADDR_W;

    logic [N_TAPS-1:0] taps;

    // A delay of BASE_CYC + STEP_CYC*a cycles sits at stage index one lower
    for (genvar a = 0; a < N_TAPS; a++) begin : g_tap
        assign taps[a] = stages[BASE_CYC + STEP_CYC * a - 1];
    end

    assign tap = taps[sel];

endmodule

// File: rtl/pdl_out_stage.sv
module pdl_out_stage (
    input  logic tap,
    input  logic en_n,
    output logic dout,
    output logic dout_n
);

    always_comb begin
        if (en_n) begin
            dout   = 1'b0;
            dout_n = 1'b1;
        end else begin
            dout   = tap;
            dout_n = ~tap;
        end
    end

endmodule

// File: rtl/pdl_width_monitor.sv
module pdl_width_monitor
    import pdl_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int PCT   = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [DLY_W-1:0] total_cyc,
    output logic             pw_err
);

    pw_state_t        state, state_nx;
    logic             din_q;
    logic [CNT_W-1:0] run_len, run_nx;
    logic [CNT_W-1:0] min_len;
    logic             changed;

    assign changed = din ^ din_q;

    always_comb begin
        min_len = CNT_W'(ceil_pct(32'(total_cyc), PCT));
    end

    // Next state and next run length
    always_comb begin
        state_nx = state;
        run_nx   = run_len;
        unique case (state)
            PW_SETTLE: begin
                if (changed) begin
                    state_nx = PW_TRACK;
                    run_nx   = CNT_W'(1);
                end
            end
            PW_TRACK: begin
                if (changed) begin
                    if (run_len < min_len) begin
                        state_nx = PW_FAULT;
                    end
                    run_nx = CNT_W'(1);
                end else if (run_len != '1) begin
                    run_nx = run_len + CNT_W'(1);
                end
            end
            PW_FAULT: begin
                state_nx = PW_FAULT;
            end
            default: begin
                state_nx = PW_SETTLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PW_SETTLE;
            din_q   <= 1'b0;
            run_len <= '0;
        end else begin
            state   <= state_nx;
            din_q   <= din;
            run_len <= run_nx;
        end
    end

    // Outputs
    always_comb begin
        pw_err = (state == PW_FAULT);
    end

endmodule

// File: rtl/pulse_delay_line.sv
module pulse_delay_line
    import pdl_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BASE_CYC  = 1,
    parameter int STEP_CYC  = 1,
    parameter int MINPW_PCT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [ADDR_W-1:0] sel,
    input  logic              en_n,
    output logic              dout,
    output logic              dout_n,
    output logic              pw_err
);

    localparam int N_ADDR = 1 << ADDR_W;
    localparam int DEPTH  = BASE_CYC + STEP_CYC * (N_ADDR - 1);
    localparam int DLY_W  = $clog2(DEPTH + 1);
    localparam int MAX_PW = int'(ceil_pct(DEPTH, MINPW_PCT));
    localparam int CNT_W  = $clog2(MAX_PW + 1) + 1;

    logic [DEPTH-1:0] stages;
    logic             tap;
    logic [DLY_W-1:0] total_cyc;

    always_comb begin
        total_cyc = DLY_W'(BASE_CYC + STEP_CYC * int'(sel));
    end

    pdl_tap_chain #(
        .DEPTH (DEPTH)
    ) u_chain (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .stages (stages)
    );

    pdl_tap_mux #(
        .ADDR_W   (ADDR_W),
        .BASE_CYC (BASE_CYC),
        .STEP_CYC (STEP_CYC),
        .DEPTH    (DEPTH)
    ) u_mux (
        .stages (stages),
        .sel    (sel),
        .tap    (tap)
    );

    pdl_out_stage u_out (
        .tap    (tap),
        .en_n   (en_n),
        .dout   (dout),
        .dout_n (dout_n)
    );

    pdl_width_monitor #(
        .DLY_W (DLY_W),
        .PCT   (MINPW_PCT),
        .CNT_W (CNT_W)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .total_cyc (total_cyc),
        .pw_err    (pw_err)
    );

endmodule

// File: rtl/pdl_checker.sv
module pdl_checker (
    input logic clk,
    input logic rst,
    input logic din,
    input logic en_n,
    input logic dout,
    input logic dout_n,
    input logic pw_err
);

    assert_forced_levels_R5: assert property (@(posedge clk) disable iff (rst)
        en_n |-> (!dout && dout_n));

    assert_complement_R4: assert property (@(posedge clk) disable iff (rst)
        !en_n |-> (dout_n == !dout));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        pw_err |=> pw_err);

    assert_err_after_change_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pw_err) |-> ($past(din) != $past(din, 2)));

    assert_clear_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dout && dout_n && !pw_err));

endmodule

bind pulse_delay_line pdl_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .en_n   (en_n),
    .dout   (dout),
    .dout_n (dout_n),
    .pw_err (pw_err)
);

// File: tb/tb_pulse_delay_line.sv
module tb_pulse_delay_line;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [6:0] sel = '0;
    logic       en_n = 1'b0;
    logic       dout, dout_n, pw_err;

    int n_chk  = 0;
    int n_fail = 0;
    logic hist[$];

    always #5 clk = ~clk;

    pulse_delay_line dut (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .sel    (sel),
        .en_n   (en_n),
        .dout   (dout),
        .dout_n (dout_n),
        .pw_err (pw_err)
    );

    // Independent record of applied input, newest first
    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
        end else begin
            hist.push_front(din);
            if (hist.size() > 200) void'(hist.pop_back());
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_tap();
        int d = 1 + int'(sel);
        if (hist.size() >= d) return hist[d-1];
        return 1'b0;
    endfunction

    task automatic step(input logic d, input logic [6:0] a, input logic e,
                        input string req);
        logic t;
        @(negedge clk);
        din  = d;
        sel  = a;
        en_n = e;
        #1;
        t = model_tap();
        chk(req, dout,   e ? 1'b0 : t);
        chk(req, dout_n, e ? 1'b1 : ~t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; din = 1'b0; en_n = 1'b0; sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R7 reset dout", dout, 1'b0);
        chk("R7 reset dout_n", dout_n, 1'b1);
        chk("R7 reset err", pw_err, 1'b0);
    endtask

    // R1 R2 R4: random pulse train at a fixed select value
    task automatic t_fixed(input logic [6:0] a);
        logic lvl = 1'b0;
        int   left = 0;
        do_reset();
        for (int i = 0; i < 300; i++) begin
            if (left == 0) begin
                lvl  = ~lvl;
                left = 1 + int'($urandom_range(5));
            end
            left--;
            step(lvl, a, 1'b0, "R1 R2 R4 fixed select");
        end
    endtask

    // R3: delay grows with select value
    task automatic t_monotonic();
        int prev = 0;
        int vals[6] = '{0, 1, 2, 63, 126, 127};
        foreach (vals[k]) begin
            int seen = -1;
            do_reset();
            step(1'b0, 7'(vals[k]), 1'b0, "R3 prep");
            step(1'b1, 7'(vals[k]), 1'b0, "R3 edge");
            for (int i = 1; i <= 140 && seen < 0; i++) begin
                step(1'b1, 7'(vals[k]), 1'b0, "R3 wait");
                if (dout === 1'b1) seen = i;
            end
            n_chk++;
            if (seen != vals[k] + 1 || seen < prev) begin
                n_fail++;
                $display("FAIL R3: delay actual %0d expected %0d", seen, vals[k] + 1);
            end
            prev = seen;
        end
    endtask

    // R3: select changed on the fly takes effect at once
    task automatic t_live_sel();
        logic [6:0] a = 7'd10;
        do_reset();
        for (int i = 0; i < 400; i++) begin
            if (i % 7 == 0) a = 7'($urandom_range(127));
            step(1'($urandom_range(1)), a, 1'b0, "R3 live select");
        end
    endtask

    // R5 R6: enable toggled while data flows
    task automatic t_disable();
        logic e = 1'b0;
        do_reset();
        for (int i = 0; i < 400; i++) begin
            if (i % 13 == 0) e = 1'($urandom_range(1));
            step(1'($urandom_range(1)), 7'd20, e, "R5 R6 enable");
        end
    endtask

    // R7: reset flushes a chain full of ones
    task automatic t_reset_flush();
        do_reset();
        for (int i = 0; i < 150; i++) step(1'b1, 7'd127, 1'b0, "R7 fill");
        do_reset();
        for (int i = 0; i < 140; i++) step(1'b1, 7'd127, 1'b0, "R7 flush");
    endtask

    task automatic hold(input logic d, input int n, input logic [6:0] a);
        for (int i = 0; i < n; i++) step(d, a, 1'b0, "R8 width stim");
    endtask

    task automatic t_width();
        do_reset();
        hold(1'b0, 5, 7'd127);
        hold(1'b1, 11, 7'd127);
        hold(1'b0, 11, 7'd127);
        hold(1'b1, 11, 7'd127);
        hold(1'b0, 20, 7'd127);
        chk("R10 11-cycle levels at sel 127", pw_err, 1'b0);
        hold(1'b1, 10, 7'd127);
        hold(1'b0, 3, 7'd127);
        chk("R8 10-cycle level at sel 127", pw_err, 1'b1);
        for (int i = 0; i < 30; i++) step(1'(i % 5 == 0), 7'd0, 1'b0, "R9 stim");
        chk("R9 error held", pw_err, 1'b1);
        do_reset();
        #1;
        chk("R9 error cleared by reset", pw_err, 1'b0);
        for (int i = 0; i < 20; i++) step(1'(i % 2), 7'd0, 1'b0, "R10 stim");
        chk("R10 1-cycle levels at sel 0", pw_err, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fixed(7'd0);
        t_fixed(7'd5);
        t_fixed(7'd64);
        t_fixed(7'd127);
        t_monotonic();
        t_live_sel();
        t_disable();
        t_reset_flush();
        t_width();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule